// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block turns parallel words into a serial bit stream. Alongside the data it produces a bit clock and a one-bit frame pulse that announces each word. A word enters through a ready/valid handshake and waits in a holding register. At the start of its frame it moves into a shift register. The holding register is then free again, so the next word can be written while the current one is still going out. Static configuration inputs set the word length (3 to 16 bits), the bit order, the bit-clock divider, and whether the bit clock and the frame pulse are generated inside the block or taken from outside.

Every register runs on the system clock. The bit clock is a clock-enable event, not a separate clock. In internal mode a divider makes this event. In external mode a synchronizer edge-detects the incoming bit clock to make it. Data is launched on the rising edge of the bit clock, so a receiver can capture it on the falling edge. If a frame starts while no word is waiting, the block sends zeros for that frame and sets a sticky underflow flag, which software clears by writing 1 to it. The configuration is expected to change only while no word is being sent.

Top module: `sertx_top`

## Requirements
- R1: The word length comes from `cfg_len`. Values from 3 to 16 are used as given, values below 3 act as 3, and values above 16 act as 16.
- R2: With `cfg_lsb_first`=0 the word goes out from bit len-1 down to bit 0. With `cfg_lsb_first`=1 it goes out from bit 0 up to bit len-1. Words are right-justified in `in_data`, and bits at position len and above are never sent.
- R3: `in_ready` is 1 exactly when the holding register is empty. An accepted word leaves the holding register on the bit-clock rise where its frame starts. When a word is waiting at the end of the previous word, its first bit follows the previous last bit with no idle bit between them.
- R4: With `cfg_int_clk`=1, `bclk_out` has a period of 2*(`cfg_div`+1) system clocks. `sdata` changes only on a rising `bclk_out`.
- R5: With `cfg_int_fs`=1, `fs_out` goes high only while a word is waiting. It stays high for one bit period, the period just before the first data bit, which overlaps the last bit of a word still being sent.
- R6: With `cfg_int_clk`=0, each rising edge of `bclk_in` paces the output after a two-stage synchronizer, and `bclk_out` stays 0.
- R7: With `cfg_int_fs`=0, `fs_in` is sampled at each bit-clock rise. When it is sampled high, data starts on the next rise, and `fs_out` stays 0.
- R8: If a frame starts with the holding register empty, that frame carries all zeros and `uf_flag` is set. The flag holds until `uf_clr` is 1. If a set and a clear happen in the same cycle, the set wins.
- R9: After reset `in_ready`=1, and `sdata`, `fs_out`, `bclk_out` and `uf_flag` are 0. `sdata` is 0 on every bit period that carries no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 5 | Word length in bits |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_int_clk | input | 1 | 1: generate bit clock internally |
| cfg_int_fs | input | 1 | 1: generate frame pulse internally |
| cfg_div | input | 16 | Bit-clock divider value |
| in_valid | input | 1 | Parallel word valid |
| in_data | input | 16 | Parallel word, right-justified |
| in_ready | output | 1 | Holding register can take a word |
| bclk_in | input | 1 | External bit clock |
| fs_in | input | 1 | External frame pulse |
| bclk_out | output | 1 | Generated bit clock |
| fs_out | output | 1 | Generated frame pulse |
| sdata | output | 1 | Serial data |
| uf_flag | output | 1 | Sticky underflow flag |
| uf_clr | input | 1 | Write 1 to clear `uf_flag` |

## Verification
The bench probes several corner cases, each of which a plausible design error would expose:

- Clamped and oversized lengths, and short words whose upper bits are set. A design that fails to clamp or mask would send the wrong number of bits or leak high-order bits into an MSB-first word.
- Two words written back to back. A design that fires the frame pulse only once it is idle would insert a dead bit between the words.
- A frame that starts on an empty holding register. A design that reuses the stale holding contents would send old data instead of zeros, or fail to latch the underflow flag.
- External framing, where the sampling point relative to the synchronized clock is checked. A design off by one bit would shift every captured word.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned MIN_WORD = 3;

  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } order_e;

  // one system-clock-wide event: a bit-clock rise, with the frame input seen there
  typedef struct packed {
    logic rise;
    logic fs;
  } bit_evt_t;
endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk
  import sertx_pkg::*;
#(
  parameter int DIVW = 16,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            int_clk,
  input  logic [DIVW-1:0] div,
  input  logic            bclk_in,
  input  logic            fs_in,
  output bit_evt_t        evt,
  output logic            bclk_q
);
  logic [DIVW-1:0] cnt_q, cnt_d;
  logic            bclk_d;
  logic            wrap;
  logic [SYNC:0]   clk_s;
  logic [SYNC-1:0] fs_s;

  // synchronizer chains for the external clock and frame pulse
  for (genvar g = 0; g <= SYNC; g++) begin : g_clk_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) clk_s[g] <= 1'b0;
        else        clk_s[g] <= bclk_in;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) clk_s[g] <= 1'b0;
        else        clk_s[g] <= clk_s[g-1];
    end
  end

  for (genvar g = 0; g < SYNC; g++) begin : g_fs_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) fs_s[g] <= 1'b0;
        else        fs_s[g] <= fs_in;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) fs_s[g] <= 1'b0;
        else        fs_s[g] <= fs_s[g-1];
    end
  end

  assign wrap = (cnt_q >= div);

  always_comb begin
    cnt_d  = cnt_q;
    bclk_d = bclk_q;
    if (int_clk) begin
      if (wrap) begin
        cnt_d  = '0;
        bclk_d = ~bclk_q;
      end else begin
        cnt_d = cnt_q + DIVW'(1);
      end
    end else begin
      cnt_d  = '0;
      bclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  always_comb begin
    evt.rise = int_clk ? (wrap & ~bclk_q) : (clk_s[SYNC-1] & ~clk_s[SYNC]);
    evt.fs   = fs_s[SYNC-1];
  end
endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  output logic          full_q,
  output logic [DW-1:0] data_q
);
  logic accept;
  logic full_d;

  assign accept   = in_valid & ~full_q;
  assign in_ready = ~full_q;

  always_comb begin
    full_d = full_q;
    if (accept)    full_d = 1'b1;
    else if (take) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (accept) data_q <= in_data;
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DW = 16,
  localparam int LW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bit_evt_t      evt,
  input  logic          int_fs,
  input  logic [LW-1:0] len,
  input  logic          lsb_first,
  input  logic          buf_full,
  input  logic [DW-1:0] buf_data,
  output logic          take,
  output logic          uf_set,
  output logic          sd_q,
  output logic          fs_q
);
  logic [DW-1:0] sr_q, sr_d, ld_word, aligned;
  logic [LW-1:0] cnt_q, cnt_d, len_c, sh;
  logic          sd_d, fs_d, pend_q, pend_d;
  order_e        ord;

  assign ord = order_e'(lsb_first);

  always_comb begin
    if (len < LW'(MIN_WORD))  len_c = LW'(MIN_WORD);
    else if (len > LW'(DW))   len_c = LW'(DW);
    else                      len_c = len;
    sh      = LW'(DW) - len_c;
    ld_word = buf_full ? buf_data : '0;
    aligned = (ord == ORDER_LSB) ? ld_word : (ld_word << sh);
  end

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    sd_d   = sd_q;
    fs_d   = fs_q;
    pend_d = pend_q;
    take   = 1'b0;
    uf_set = 1'b0;
    if (evt.rise) begin
      if (pend_q) begin
        take   = buf_full;
        uf_set = ~buf_full;
        sd_d   = (ord == ORDER_LSB) ? aligned[0] : aligned[DW-1];
        sr_d   = (ord == ORDER_LSB) ? (aligned >> 1) : (aligned << 1);
        cnt_d  = len_c - LW'(1);
      end else if (cnt_q != '0) begin
        sd_d  = (ord == ORDER_LSB) ? sr_q[0] : sr_q[DW-1];
        sr_d  = (ord == ORDER_LSB) ? (sr_q >> 1) : (sr_q << 1);
        cnt_d = cnt_q - LW'(1);
      end else begin
        sd_d = 1'b0;
      end
      if (int_fs) begin
        fs_d   = buf_full & ~pend_q & (cnt_d == '0);
        pend_d = fs_d;
      end else begin
        fs_d   = 1'b0;
        pend_d = evt.fs;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      sd_q   <= 1'b0;
      fs_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      sd_q   <= sd_d;
      fs_q   <= fs_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DW   = 16,
  parameter int DIVW = 16,
  localparam int LW  = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   cfg_len,
  input  logic            cfg_lsb_first,
  input  logic            cfg_int_clk,
  input  logic            cfg_int_fs,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  input  logic            bclk_in,
  input  logic            fs_in,
  output logic            bclk_out,
  output logic            fs_out,
  output logic            sdata,
  output logic            uf_flag,
  input  logic            uf_clr
);
  logic [1:0]    rs_q;
  logic          rst_i;
  bit_evt_t      evt;
  logic          bclk_q;
  logic          take, uf_set, full_q, uf_d;
  logic [DW-1:0] buf_data;

  // reset asserts at once and releases two clocks later
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_i = rs_q[1];

  sertx_bitclk #(.DIVW(DIVW), .SYNC(2)) u_bitclk (
    .clk(clk), .rst_n(rst_i), .int_clk(cfg_int_clk), .div(cfg_div),
    .bclk_in(bclk_in), .fs_in(fs_in), .evt(evt), .bclk_q(bclk_q)
  );

  sertx_holdbuf #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_i), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(take), .full_q(full_q), .data_q(buf_data)
  );

  sertx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_i), .evt(evt), .int_fs(cfg_int_fs), .len(cfg_len),
    .lsb_first(cfg_lsb_first), .buf_full(full_q), .buf_data(buf_data),
    .take(take), .uf_set(uf_set), .sd_q(sdata), .fs_q(fs_out)
  );

  always_comb uf_d = uf_set | (uf_flag & ~uf_clr);

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) uf_flag <= 1'b0;
    else        uf_flag <= uf_d;

  assign bclk_out = cfg_int_clk & bclk_q;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_int_clk,
  input logic cfg_int_fs,
  input logic in_valid,
  input logic in_ready,
  input logic sdata,
  input logic bclk_out,
  input logic fs_out,
  input logic uf_flag,
  input logic uf_clr
);
  assert_launch_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_int_clk && !$stable(sdata)) |-> $rose(bclk_out));

  assert_fs_needs_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_int_fs && $rose(fs_out)) |-> !in_ready);

  assert_fs_ends_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_int_clk && $fell(fs_out)) |-> $rose(bclk_out));

  assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_uf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_flag && !uf_clr) |=> uf_flag);
endmodule

bind sertx_top sertx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_int_clk(cfg_int_clk), .cfg_int_fs(cfg_int_fs),
  .in_valid(in_valid), .in_ready(in_ready), .sdata(sdata), .bclk_out(bclk_out),
  .fs_out(fs_out), .uf_flag(uf_flag), .uf_clr(uf_clr)
);

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_len = 5'd8;
  logic        cfg_lsb_first = 1'b0;
  logic        cfg_int_clk = 1'b1;
  logic        cfg_int_fs = 1'b1;
  logic [15:0] cfg_div = 16'd3;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        bclk_in = 1'b0;
  logic        fs_in = 1'b0;
  logic        bclk_out, fs_out, sdata, uf_flag;
  logic        uf_clr = 1'b0;
  logic        ext_run = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sertx_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
    .cfg_int_clk(cfg_int_clk), .cfg_int_fs(cfg_int_fs), .cfg_div(cfg_div),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bclk_in(bclk_in), .fs_in(fs_in), .bclk_out(bclk_out), .fs_out(fs_out),
    .sdata(sdata), .uf_flag(uf_flag), .uf_clr(uf_clr)
  );

  // vector: {len[4:0], lsb_first, div[3:0], data[15:0]}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {5'd8,  1'b0, 4'd1, 16'h00A5},
    {5'd8,  1'b1, 4'd0, 16'h00A5},
    {5'd16, 1'b0, 4'd2, 16'hC3E1},
    {5'd16, 1'b1, 4'd1, 16'h8001},
    {5'd3,  1'b0, 4'd0, 16'hFFF6},
    {5'd5,  1'b1, 4'd3, 16'hAB53},
    {5'd1,  1'b0, 4'd0, 16'h0006},
    {5'd31, 1'b1, 4'd0, 16'h1234}
  };

  // external bit clock: half period of 6 system clocks
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        n++;
        if (n == 6) begin
          bclk_in = ~bclk_in;
          n = 0;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int eff_len(input int l);
    return (l < 3) ? 3 : ((l > 16) ? 16 : l);
  endfunction

  function automatic logic [15:0] exp_bits(input logic [15:0] d, input int l, input logic lsb);
    logic [15:0] r = '0;
    int L = eff_len(l);
    for (int i = 0; i < L; i++) r[i] = lsb ? d[i] : d[L-1-i];
    return r;
  endfunction

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    in_data  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    p = bclk_out;
    @(negedge clk);
    while (!(!p && bclk_out)) begin
      p = bclk_out;
      @(negedge clk);
    end
  endtask

  task automatic get_int_word(input int len, output logic [15:0] bits);
    bits = '0;
    @(negedge clk);
    while (!fs_out) @(negedge clk);
    wait_rise();
    for (int i = 0; i < len; i++) begin
      bits[i] = sdata;
      if (i < len - 1) wait_rise();
    end
  endtask

  task automatic get_ext_word(input int len, output logic [15:0] bits, output logic side_ok);
    bits = '0;
    side_ok = 1'b1;
    @(negedge bclk_in);
    fs_in = 1'b1;
    @(negedge bclk_in);
    fs_in = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge bclk_in);
      bits[i] = sdata;
      if (bclk_out || fs_out) side_ok = 1'b0;
    end
  endtask

  task automatic measure(output int n);
    logic p;
    wait_rise();
    p = bclk_out;
    @(negedge clk);
    n = 1;
    while (!(!p && bclk_out)) begin
      p = bclk_out;
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] got, gotb;
    logic        side;
    int          n;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(in_ready == 1'b1, "R9 in_ready", 32'(in_ready), 1);
    chk(sdata == 1'b0, "R9 sdata", 32'(sdata), 0);
    chk(fs_out == 1'b0, "R9 fs_out", 32'(fs_out), 0);
    chk(bclk_out == 1'b0, "R9 bclk_out", 32'(bclk_out), 0);
    chk(uf_flag == 1'b0, "R9 uf_flag", 32'(uf_flag), 0);

    // R4: divider period
    cfg_div = 16'd2;
    repeat (2) wait_rise();
    measure(n);
    chk(n == 6, "R4 period div=2", 32'(n), 6);
    cfg_div = 16'd0;
    repeat (2) wait_rise();
    measure(n);
    chk(n == 2, "R4 period div=0", 32'(n), 2);

    // R1/R2 table of words, each followed by an idle bit check (R9)
    for (int v = 0; v < NV; v++) begin
      logic [4:0]  l;
      logic        o;
      logic [3:0]  d;
      logic [15:0] w;
      logic [15:0] m;
      {l, o, d, w} = VEC[v];
      @(negedge clk);
      cfg_len = l;
      cfg_lsb_first = o;
      cfg_div = 16'(d);
      push(w);
      get_int_word(eff_len(int'(l)), got);
      m = 16'((32'h1 << eff_len(int'(l))) - 1);
      chk((got & m) == exp_bits(w, int'(l), o), "R1/R2 word",
          32'(got & m), 32'(exp_bits(w, int'(l), o)));
      wait_rise();
      chk(sdata == 1'b0, "R9 idle bit", 32'(sdata), 0);
    end

    // R3/R5: back-to-back words without a gap
    @(negedge clk);
    cfg_len = 5'd4;
    cfg_lsb_first = 1'b0;
    cfg_div = 16'd1;
    push(16'h0009);
    fork
      push(16'hFFF6);
      begin
        get_int_word(4, got);
        chk(fs_out == 1'b1, "R5 fs with last bit", 32'(fs_out), 1);
        gotb = '0;
        for (int i = 0; i < 4; i++) begin
          wait_rise();
          gotb[i] = sdata;
        end
      end
    join
    chk(got[3:0] == 4'b1001, "R3 first word", 32'(got[3:0]), 32'h9);
    chk(gotb[3:0] == 4'b0110, "R3 second word gapless", 32'(gotb[3:0]), 32'h6);
    wait_rise();
    wait_rise();

    // R6/R7: external clock and frame pulse
    @(negedge clk);
    cfg_int_clk = 1'b0;
    cfg_int_fs = 1'b0;
    cfg_len = 5'd8;
    cfg_lsb_first = 1'b0;
    ext_run = 1'b1;
    push(16'h00C5);
    get_ext_word(8, got, side);
    chk(got[7:0] == 8'b1010_0011, "R7 external word", 32'(got[7:0]), 32'hA3);
    chk(side, "R6 bclk_out/fs_out low", 32'(side), 1);
    chk(uf_flag == 1'b0, "R8 no underflow yet", 32'(uf_flag), 0);

    // R8: underflow
    get_ext_word(8, got, side);
    chk(got[7:0] == 8'h00, "R8 zeros on underflow", 32'(got[7:0]), 0);
    chk(uf_flag == 1'b1, "R8 flag set", 32'(uf_flag), 1);
    repeat (20) @(negedge clk);
    chk(uf_flag == 1'b1, "R8 flag sticky", 32'(uf_flag), 1);
    uf_clr = 1'b1;
    @(negedge clk);
    uf_clr = 1'b0;
    @(negedge clk);
    chk(uf_flag == 1'b0, "R8 flag cleared", 32'(uf_flag), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule